// File: doc/BRIEF.md
# Bit-Clock and Frame-Pulse Generator

This block derives a slow serial bit clock from the system clock by integer division. On top of that clock it produces a repeating frame pulse. The divider and the frame sequencer each have their own enable. The divider is started first. Once the settle indication shows that two full bit-clock periods have run, the frame sequencer may be enabled. From then on it marks the start of every frame. The frame's length and its pulse width are both counted in whole bit-clock periods.

Everything runs in the system clock domain. The bit clock appears in two forms. One is a one-cycle enable that marks the first system cycle of every bit-clock period, which is where the bit clock rises. The other is the level of the bit clock itself. The divide value is captured while the divider is stopped. The frame length and the pulse width are captured while the frame sequencer is idle. Changes to these inputs during operation therefore take effect only after the next stop.

Top module: `bitclk_frame_gen`

## Requirements
- R1: After a synchronous reset, `bclk`, `bclk_en`, `bclk_ready` and `fsync` are all 0.
- R2: Whenever `div_en` was 0 at the previous clock edge, `bclk`, `bclk_en`, `bclk_ready` and `fsync` are 0.
- R3: While running with divide value D, `bclk_en` is 1 for exactly one system cycle in every D+1 cycles.
- R4: The high phase of `bclk` starts on the `bclk_en` cycle and lasts ceil((D+1)/2) system cycles, so for an odd ratio the high phase is the longer one.
- R5: With D = 0, `bclk` stays 1 and `bclk_en` is 1 on every running cycle.
- R6: The first system cycle after the edge that samples `div_en` rising has `bclk_en` = 1 and `bclk` = 1.
- R7: `bclk_ready` rises exactly 2*(D+1) system cycles after the first `bclk_en`, coincident with a `bclk_en`.
- R8: A change of `div_val` while the divider runs has no effect on the period. The value sampled at the release edge stays in force until `div_en` is cleared.
- R9: The first `fsync` pulse after `fs_en` is set begins on the next `bclk_en` cycle, never between bit-clock rising edges.
- R10: With frame value P and width value W (W < P), `fsync` is high for (W+1)*(D+1) cycles in every (P+1)*(D+1) cycles.
- R11: Clearing `fs_en` forces `fsync` low from the next cycle on, and `bclk_en` carries on with its period unchanged.
- R12: Setting `fs_en` while `div_en` is 0 produces no `fsync` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_en | input | 1 | Divider release (1 = run) |
| fs_en | input | 1 | Frame sequencer release (1 = run) |
| div_val | input | DIV_W | Divide value D; ratio is D+1 |
| frame_per | input | PER_W | Frame value P; frame is P+1 bit periods |
| frame_wid | input | WID_W | Width value W; pulse is W+1 bit periods |
| bclk_en | output | 1 | One-cycle marker of each bit-clock rising edge |
| bclk | output | 1 | Bit-clock level |
| bclk_ready | output | 1 | Two full bit-clock periods elapsed since release |
| fsync | output | 1 | Frame pulse |

## Verification
Each output is produced from registers, so a release or stop of either enable shows up in the first cycle after the edge that samples it. The bench drives inputs on the falling edge and compares every output on the next falling edge against a reference built from a cycle age and the latched ratio. The settle flag is due 2*(D+1) cycles after release, and frame-pulse edges only ever fall on bit-clock marker cycles. The directed checks count cycles from the marker cycle at which each measurement begins, so every count lands on the exact cycle the requirement names.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam int unsigned DEF_DIV_W = 8;
    localparam int unsigned DEF_PER_W = 12;
    localparam int unsigned DEF_WID_W = 8;

    // number of whole bit periods before the settle flag rises
    localparam logic [1:0] SETTLE_PERIODS = 2'd2;

    typedef struct packed {
        logic bclk;   // bit clock level
        logic tick;   // first cycle of a bit period
        logic last;   // final cycle of a bit period
    } bclk_stat_t;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_RUN  = 1'b1
    } fs_state_t;

    function automatic int unsigned max_w(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bclk_div.sv
module bclk_div
    import bcfg_pkg::*;
#(
    parameter int unsigned DIV_W = DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_val,
    output bclk_stat_t       stat,
    output logic             tick_nxt
);
    localparam int unsigned HW = DIV_W + 1;

    logic             run;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] phase;
    logic [HW-1:0]    hi_len;

    assign hi_len = ({1'b0, div_q} + HW'(2)) >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            div_q <= '0;
            phase <= '0;
        end else begin
            run <= en;
            if (!run)
                div_q <= div_val;
            if (en && run)
                phase <= (phase == div_q) ? '0 : phase + 1'b1;
            else
                phase <= '0;
        end
    end

    assign stat.tick = run && (phase == '0);
    assign stat.last = run && (phase == div_q);
    assign stat.bclk = run && ({1'b0, phase} < hi_len);
    assign tick_nxt  = en && (!run || (phase == div_q));

endmodule

// File: rtl/bclk_settle.sv
module bclk_settle
    import bcfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic period_end,
    output logic ready
);
    logic [1:0] done_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            done_cnt <= '0;
        else if (period_end && (done_cnt != SETTLE_PERIODS))
            done_cnt <= done_cnt + 2'd1;
    end

    assign ready = (done_cnt == SETTLE_PERIODS);

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import bcfg_pkg::*;
#(
    parameter int unsigned PER_W = DEF_PER_W,
    parameter int unsigned WID_W = DEF_WID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             div_en,
    input  logic             tick_nxt,
    input  logic [PER_W-1:0] frame_per,
    input  logic [WID_W-1:0] frame_wid,
    output logic             fsync
);
    localparam int unsigned CW = max_w(PER_W, WID_W);

    fs_state_t        st;
    logic [PER_W-1:0] per_q;
    logic [WID_W-1:0] wid_q;
    logic [PER_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= FS_IDLE;
            per_q <= '0;
            wid_q <= '0;
            slot  <= '0;
        end else begin
            if (st == FS_IDLE) begin
                per_q <= frame_per;
                wid_q <= frame_wid;
            end
            if (!en || !div_en) begin
                st   <= FS_IDLE;
                slot <= '0;
            end else if (tick_nxt) begin
                if (st == FS_IDLE) begin
                    st   <= FS_RUN;
                    slot <= '0;
                end else begin
                    slot <= (slot == per_q) ? '0 : slot + 1'b1;
                end
            end
        end
    end

    assign fsync = (st == FS_RUN) && (CW'(slot) <= CW'(wid_q));

endmodule

// File: rtl/bitclk_frame_gen.sv
module bitclk_frame_gen
    import bcfg_pkg::*;
#(
    parameter int unsigned DIV_W = DEF_DIV_W,
    parameter int unsigned PER_W = DEF_PER_W,
    parameter int unsigned WID_W = DEF_WID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_en,
    input  logic             fs_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PER_W-1:0] frame_per,
    input  logic [WID_W-1:0] frame_wid,
    output logic             bclk_en,
    output logic             bclk,
    output logic             bclk_ready,
    output logic             fsync
);
    bclk_stat_t stat;
    logic       tick_nxt;

    bclk_div #(.DIV_W(DIV_W)) i_div (
        .clk      (clk),
        .rst      (rst),
        .en       (div_en),
        .div_val  (div_val),
        .stat     (stat),
        .tick_nxt (tick_nxt)
    );

    bclk_settle i_settle (
        .clk        (clk),
        .rst        (rst),
        .en         (div_en),
        .period_end (stat.last),
        .ready      (bclk_ready)
    );

    frame_seq #(.PER_W(PER_W), .WID_W(WID_W)) i_fs (
        .clk       (clk),
        .rst       (rst),
        .en        (fs_en),
        .div_en    (div_en),
        .tick_nxt  (tick_nxt),
        .frame_per (frame_per),
        .frame_wid (frame_wid),
        .fsync     (fsync)
    );

    assign bclk_en = stat.tick;
    assign bclk    = stat.bclk;

endmodule

// File: rtl/bitclk_frame_gen_chk.sv
module bitclk_frame_gen_chk (
    input logic clk,
    input logic rst,
    input logic div_en,
    input logic fs_en,
    input logic bclk_en,
    input logic bclk,
    input logic bclk_ready,
    input logic fsync
);
    // R2: a stopped divider silences every output
    p_held_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !div_en |=> (!bclk && !bclk_en && !bclk_ready && !fsync));

    // R6: release starts with a rising bit clock
    p_first_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(div_en) |=> (bclk_en && bclk));

    // R7: settle flag rises only on a bit-clock marker
    p_ready_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_ready) |-> bclk_en);

    // R9: frame pulse starts only on a bit-clock marker
    p_fs_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync) |-> bclk_en);

    // R11: clearing the frame release drops the pulse next cycle
    p_fs_stop_r11: assert property (@(posedge clk) disable iff (rst)
        !fs_en |=> !fsync);

    // R4: the bit clock is high whenever a marker is present
    p_tick_high_r4: assert property (@(posedge clk) disable iff (rst)
        bclk_en |-> bclk);

endmodule

bind bitclk_frame_gen bitclk_frame_gen_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .div_en     (div_en),
    .fs_en      (fs_en),
    .bclk_en    (bclk_en),
    .bclk       (bclk),
    .bclk_ready (bclk_ready),
    .fsync      (fsync)
);

// File: tb/test_bitclk_frame_gen.sv
module test_bitclk_frame_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        div_en = 1'b0;
    logic        fs_en = 1'b0;
    logic [7:0]  div_val = '0;
    logic [11:0] frame_per = '0;
    logic [7:0]  frame_wid = '0;
    logic        bclk_en, bclk, bclk_ready, fsync;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit primed  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitclk_frame_gen i_bitclk_frame_gen (
        .clk(clk), .rst(rst), .div_en(div_en), .fs_en(fs_en),
        .div_val(div_val), .frame_per(frame_per), .frame_wid(frame_wid),
        .bclk_en(bclk_en), .bclk(bclk), .bclk_ready(bclk_ready), .fsync(fsync)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // reference model: cycle age since release and the latched ratios
    int m_run = 0, m_age = 0, m_n = 1;
    int fs_on = 0, fs_t0 = 0, fs_p = 1, fs_w = 1;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_run = 0; m_age = 0; m_n = 1; fs_on = 0;
        end else begin
            if (!div_en) m_run = 0;
            else if (m_run == 0) begin
                m_run = 1; m_age = 0; m_n = int'(div_val) + 1;
            end else m_age++;
            if (!fs_en || !div_en) fs_on = 0;
            else if (!fs_on && (m_age % m_n) == 0) begin
                fs_on = 1; fs_t0 = m_age;
                fs_p = int'(frame_per) + 1; fs_w = int'(frame_wid) + 1;
            end
        end
        primed = 1;
    end

    always @(negedge clk) begin
        if (primed && !done) begin
            int ph;
            ph = m_age % m_n;
            check("R3 bclk_en", int'(bclk_en), (m_run != 0 && ph == 0) ? 1 : 0);
            check("R4 bclk", int'(bclk), (m_run != 0 && ph < (m_n + 1) / 2) ? 1 : 0);
            check("R7 bclk_ready", int'(bclk_ready), (m_run != 0 && m_age >= 2 * m_n) ? 1 : 0);
            check("R10 fsync", int'(fsync),
                  (fs_on != 0 && (((m_age - fs_t0) / m_n) % fs_p) < fs_w) ? 1 : 0);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cnt;
        int total;
        step(3);
        check("R1 bclk", int'(bclk), 0);
        check("R1 bclk_en", int'(bclk_en), 0);
        check("R1 bclk_ready", int'(bclk_ready), 0);
        check("R1 fsync", int'(fsync), 0);
        rst = 1'b0;

        // R12 / R2: frame release without a running divider
        div_val = 8'd5; frame_per = 12'd2; fs_en = 1'b1;
        step(8);
        check("R12 fsync", int'(fsync), 0);
        check("R2 bclk", int'(bclk), 0);
        fs_en = 1'b0;

        // R6: release with ratio 4
        div_val = 8'd3; div_en = 1'b1;
        step(1);
        check("R6 bclk_en", int'(bclk_en), 1);
        check("R6 bclk", int'(bclk), 1);
        cnt = 0;
        while (!bclk_ready) begin cnt++; step(1); end
        check("R7 settle cycles", cnt, 8);

        // R8: ratio change while running is ignored
        div_val = 8'd7;
        while (!bclk_en) step(1);
        step(1); cnt = 1;
        while (!bclk_en) begin cnt++; step(1); end
        check("R8 period", cnt, 4);

        // R9 / R10: frame of 4 bit periods, pulse of 2
        frame_per = 12'd3; frame_wid = 8'd1; fs_en = 1'b1;
        step(1);
        while (!fsync) step(1);
        check("R9 start on tick", int'(bclk_en), 1);
        cnt = 0;
        while (fsync) begin cnt++; step(1); end
        check("R10 width", cnt, 8);
        total = cnt;
        while (!fsync) begin total++; step(1); end
        check("R10 frame", total, 16);

        // R11: stopping the frame pulse leaves the bit clock alone
        fs_en = 1'b0;
        step(1);
        check("R11 fsync", int'(fsync), 0);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            if (bclk_en) cnt++;
            check("R11 fsync low", int'(fsync), 0);
            step(1);
        end
        check("R11 ticks", cnt, 2);

        // R2 then R4 with odd ratio 5
        div_en = 1'b0;
        step(1);
        check("R2 bclk", int'(bclk), 0);
        check("R2 ready", int'(bclk_ready), 0);
        div_val = 8'd4; div_en = 1'b1;
        step(1);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            if (bclk) cnt++;
            step(1);
        end
        check("R4 odd high", cnt, 3);
        step(20);

        // R5: ratio 1, plus a frame pulse at full rate
        div_en = 1'b0;
        step(1);
        div_val = 8'd0; div_en = 1'b1;
        step(1);
        for (int i = 0; i < 6; i++) begin
            check("R5 bclk", int'(bclk), 1);
            check("R5 bclk_en", int'(bclk_en), 1);
            step(1);
        end
        frame_per = 12'd4; frame_wid = 8'd2; fs_en = 1'b1;
        step(30);
        fs_en = 1'b0;
        step(3);
        finish_run();
    end

endmodule